// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a 32-bit down-counter that raises a one-cycle interrupt request carrying an 8-bit vector. Software programs it through a small word-wide register port: a prescaler code, a reload value and a control entry. The control entry holds a suppress bit, a repeat-or-single-shot select, a three-bit delivery kind and the vector. The counter advances on divided ticks. A divided tick is formed from a base clock-enable input by a power-of-two prescaler.

Writing the reload value loads the counter and restarts the prescaler. Each divided tick then lowers the count by one. A tick that finds the count already at zero is an expiry. After an expiry the counter either stops (single-shot) or reloads (repeat), so every interval lasts reload+1 ticks. The request is driven only when the entry is unsuppressed and its delivery kind is fixed (code 0).

The counter controller is a two-state machine. ST_STOPPED is the state after reset, after a single-shot expiry, and after loading zero. ST_COUNTING is entered by the transition LOAD_NONZERO (a reload write with a nonzero value, from either state). Inside ST_COUNTING, the transition STEP lowers the count on a tick, and the transition WRAP reloads it on an expiry in repeat mode. The transition FINISH returns the machine to ST_STOPPED on an expiry in single-shot mode. The transition LOAD_ZERO returns it to ST_STOPPED on a reload write of zero.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control entry (address 0) reads 0x0001_0000, and the prescaler code (address 1), reload value (address 2) and current count (address 3) read 0. irq_req is low.
- R2: A write to address 1 keeps only data bits 3, 1 and 0. The register reads back the written value ANDed with 0xB.
- R3: The prescaler shift is ({bit3,bit1,bit0} + 1) mod 8. A divided tick occurs once every 2^shift cycles with base_en high, counted from the last reload write, and cycles with base_en low do not count. Code 0xB therefore divides by 1 and code 0 divides by 2.
- R4: A write to address 2 makes the current count equal the written value on the next cycle and restarts the prescaler.
- R5: In single-shot mode (entry bit 17 = 0) the count falls by one per tick and stays at 0. Exactly one expiry occurs per load, on the (N+1)-th tick after loading N.
- R6: In repeat mode (entry bit 17 = 1) an expiry occurs on every (N+1)-th tick, and the count reloads N.
- R7: Loading 0 produces no expiry in either mode, and the count stays 0.
- R8: Entry bit 16 set suppresses the request while counting continues.
- R9: A delivery kind (entry bits 10:8) other than 0 suppresses the request.
- R10: An expiry drives irq_req high for exactly one cycle, the cycle after the expiring tick. During that cycle irq_vec equals entry bits 7:0. A write to the entry does not disturb the running count and takes effect at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | Base count enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register select: 0 entry, 1 prescaler code, 2 reload, 3 current count |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for addr |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_vec | output | 8 | Vector accompanying irq_req, zero otherwise |

## Verification
The bound checker watches, every cycle, that a request lasts one cycle. It also checks that a request only follows a cycle in which the entry was unsuppressed, in fixed delivery and holding the same vector. It checks that a reload write lands in the count, and that a single-shot count never rises except by reload. The exact expiry spacing for each prescaler code, the single expiry per load, the pause under a low base_en and the silence after loading zero need the bench's scenarios. These scenarios time each expected request against the edge of the reload write.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [1:0] {
        REG_ENTRY = 2'd0,
        REG_DIV   = 2'd1,
        REG_INIT  = 2'd2,
        REG_CUR   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_STOPPED  = 1'b0,
        ST_COUNTING = 1'b1
    } cnt_state_e;

    typedef struct packed {
        logic       periodic;
        logic       mask;
        logic [2:0] mode;
        logic [7:0] vector;
    } entry_t;

    localparam logic [2:0] MODE_FIXED = 3'd0;
    localparam int         SHIFT_W    = 3;

    localparam int ENT_VEC_LSB  = 0;
    localparam int ENT_MODE_LSB = 8;
    localparam int ENT_MASK_BIT = 16;
    localparam int ENT_PER_BIT  = 17;

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
    import cdt_pkg::*;
#(
    parameter int CODE_W = SHIFT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  logic              restart,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              tick
);

    localparam int PRE_W = 2 ** CODE_W;

    logic [CODE_W-1:0] shift;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  low_mask;

    // shift wraps modulo 2^CODE_W, so the all-ones code selects divide by 1
    assign shift    = cfg_code + 1'b1;
    assign low_mask = (PRE_W'(1) << shift) - PRE_W'(1);
    assign tick     = base_en && !restart && ((pre_q & low_mask) == low_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (base_en) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   cur_cnt,
    output entry_t             entry_q,
    output logic [SHIFT_W-1:0] div_code_q,
    output logic [CNT_W-1:0]   init_q,
    output logic               load,
    output logic [DATA_W-1:0]  rdata
);

    logic sel_entry, sel_div, sel_init, sel_cur;

    assign sel_entry = (addr == ADDR_W'(REG_ENTRY));
    assign sel_div   = (addr == ADDR_W'(REG_DIV));
    assign sel_init  = (addr == ADDR_W'(REG_INIT));
    assign sel_cur   = (addr == ADDR_W'(REG_CUR));
    assign load      = wr_en && sel_init;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q    <= '{periodic: 1'b0, mask: 1'b1, mode: MODE_FIXED, vector: 8'h00};
            div_code_q <= '0;
            init_q     <= '0;
        end else if (wr_en) begin
            if (sel_entry) begin
                entry_q <= '{periodic: wdata[ENT_PER_BIT],
                             mask:     wdata[ENT_MASK_BIT],
                             mode:     wdata[ENT_MODE_LSB +: 3],
                             vector:   wdata[ENT_VEC_LSB +: 8]};
            end
            if (sel_div) begin
                div_code_q <= {wdata[3], wdata[1], wdata[0]};
            end
            if (sel_init) begin
                init_q <= wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_entry) begin
            rdata[ENT_PER_BIT]        = entry_q.periodic;
            rdata[ENT_MASK_BIT]       = entry_q.mask;
            rdata[ENT_MODE_LSB +: 3]  = entry_q.mode;
            rdata[ENT_VEC_LSB +: 8]   = entry_q.vector;
        end else if (sel_div) begin
            rdata[3] = div_code_q[2];
            rdata[1] = div_code_q[1];
            rdata[0] = div_code_q[0];
        end else if (sel_init) begin
            rdata[CNT_W-1:0] = init_q;
        end else if (sel_cur) begin
            rdata[CNT_W-1:0] = cur_cnt;
        end
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             deliver_ok,
    input  logic [7:0]       vector,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             irq_req,
    output logic [7:0]       irq_vec
);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;
    logic             fire;

    // next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                if (load) begin
                    cnt_d   = load_val;
                    state_d = (load_val != '0) ? ST_COUNTING : ST_STOPPED;
                end
            end
            ST_COUNTING: begin
                if (load) begin
                    cnt_d   = load_val;
                    state_d = (load_val != '0) ? ST_COUNTING : ST_STOPPED;
                end else if (tick) begin
                    if (cnt_q == '0) begin
                        expire = 1'b1;
                        if (periodic) begin
                            cnt_d = reload_val;
                        end else begin
                            state_d = ST_STOPPED;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    assign fire = expire && deliver_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq_req <= fire;
            irq_vec <= fire ? vector : 8'h00;
        end
    end

    assign cur_cnt = cnt_q;

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_req,
    output logic [7:0]        irq_vec
);

    entry_t             entry_q;
    logic [SHIFT_W-1:0] div_code;
    logic [CNT_W-1:0]   init_val;
    logic [CNT_W-1:0]   cur_cnt;
    logic               load;
    logic               tick;
    logic               deliver_ok;

    logic               ent_mask, ent_periodic;
    logic [2:0]         ent_mode;
    logic [7:0]         ent_vec;

    assign ent_mask     = entry_q.mask;
    assign ent_periodic = entry_q.periodic;
    assign ent_mode     = entry_q.mode;
    assign ent_vec      = entry_q.vector;
    assign deliver_ok   = !ent_mask && (ent_mode == MODE_FIXED);

    cdt_regs #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .cur_cnt    (cur_cnt),
        .entry_q    (entry_q),
        .div_code_q (div_code),
        .init_q     (init_val),
        .load       (load),
        .rdata      (rdata)
    );

    cdt_prescaler #(
        .CODE_W (SHIFT_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_en  (base_en),
        .restart  (load),
        .cfg_code (div_code),
        .tick     (tick)
    );

    cdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (load),
        .load_val   (wdata[CNT_W-1:0]),
        .reload_val (init_val),
        .periodic   (ent_periodic),
        .deliver_ok (deliver_ok),
        .vector     (ent_vec),
        .cur_cnt    (cur_cnt),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec)
    );

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq_req,
    input logic [7:0]        irq_vec,
    input logic              ent_mask,
    input logic              ent_periodic,
    input logic [2:0]        ent_mode,
    input logic [7:0]        ent_vec,
    input logic [CNT_W-1:0]  cur_cnt
);

    logic init_wr;
    assign init_wr = wr_en && (addr == ADDR_W'(2));

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    p_vec_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec == $past(ent_vec)));

    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(ent_mask));

    p_mode_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(ent_mode) == 3'd0));

    p_load_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (cur_cnt == $past(wdata[CNT_W-1:0])));

    p_oneshot_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_wr && !ent_periodic) |=> (cur_cnt <= $past(cur_cnt)));

endmodule

bind cdt_timer cdt_timer_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .irq_req      (irq_req),
    .irq_vec      (irq_vec),
    .ent_mask     (ent_mask),
    .ent_periodic (ent_periodic),
    .ent_mode     (ent_mode),
    .ent_vec      (ent_vec),
    .cur_cnt      (cur_cnt)
);

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq_req;
    logic [7:0]  irq_vec;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    int last_edge = 0;
    int exp_edge_q[$];
    int exp_vec_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    cdt_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_en (base_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_req (irq_req),
        .irq_vec (irq_vec)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        #1;
        last_edge = edges;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int shift_of(input logic [31:0] d);
        return ({d[3], d[1], d[0]} + 1) % 8;
    endfunction

    task automatic expect_irq(input int edge_no, input int vec);
        exp_edge_q.push_back(edge_no);
        exp_vec_q.push_back(vec);
    endtask

    task automatic drained(input string req);
        chk(exp_edge_q.size() == 0, req, exp_edge_q.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && irq_req) begin
            if (exp_edge_q.size() == 0) begin
                chk(1'b0, "R10 unexpected request", edges, 0);
            end else begin
                int ee, ev;
                ee = exp_edge_q.pop_front();
                ev = exp_vec_q.pop_front();
                chk(edges == ee, "R5/R6 expiry edge", edges, ee);
                chk(irq_vec == 8'(ev), "R10 vector", irq_vec, ev);
            end
        end
    end

    initial begin
        int guard = 0;
        while (guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        chk(1'b0, "watchdog", guard, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] v2;
        int sh;
        int k;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(2'd0, v); chk(v == 32'h0001_0000, "R1 entry", v, 32'h0001_0000);
        rd(2'd1, v); chk(v == 0, "R1 div", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 init", v, 0);
        rd(2'd3, v); chk(v == 0, "R1 cur", v, 0);
        chk(irq_req == 1'b0, "R1 irq", irq_req, 0);

        // R2 prescaler code masking
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk(v == 32'hB, "R2 div readback", v, 32'hB);
        wr(2'd1, 32'h0000_0004);
        rd(2'd1, v); chk(v == 32'h0, "R2 div bit2 dropped", v, 0);
        wr(2'd1, 32'hB);

        // R5 single-shot, divide by 1, N=3
        wr(2'd0, 32'h0000_0041);
        sh = shift_of(32'hB);
        wr(2'd2, 32'd3);
        expect_irq(last_edge + (3 + 1) * (1 << sh), 8'h41);
        rd(2'd3, v); chk(v == 3, "R4 load visible", v, 3);
        idle(20);
        rd(2'd3, v); chk(v == 0, "R5 holds at zero", v, 0);
        drained("R5 single expiry");

        // R6 repeat, divide by 2 (code 0), N=2
        wr(2'd1, 32'h0);
        sh = shift_of(32'h0);
        wr(2'd0, 32'h0002_0052);
        wr(2'd2, 32'd2);
        k = last_edge;
        for (int i = 1; i <= 3; i++) expect_irq(k + i * 3 * (1 << sh), 8'h52);
        while (edges < k + 19) @(negedge clk);
        wr(2'd2, 32'd0);
        idle(12);
        drained("R6 repeat expiries");
        rd(2'd3, v); chk(v == 0, "R7 zero load", v, 0);

        // R3 divide by 4 (code 1), single-shot N=1
        wr(2'd1, 32'h1);
        sh = shift_of(32'h1);
        wr(2'd0, 32'h0000_0023);
        wr(2'd2, 32'd1);
        expect_irq(last_edge + 2 * (1 << sh), 8'h23);
        idle(16);
        drained("R3 divide by 4");

        // R3 base_en low pauses counting
        base_en = 1'b0;
        wr(2'd0, 32'h0000_0024);
        wr(2'd2, 32'd5);
        idle(12);
        rd(2'd3, v); chk(v == 5, "R3 paused count", v, 5);
        drained("R3 paused no request");
        k = edges;
        base_en = 1'b1;
        expect_irq(k + 6 * (1 << sh), 8'h24);
        idle(30);
        drained("R3 resumed expiry");

        // R8 suppressed repeat, divide by 1, N=1: counting continues
        wr(2'd1, 32'hB);
        wr(2'd0, 32'h0003_0011);
        wr(2'd2, 32'd1);
        idle(5);
        rd(2'd3, v);
        idle(1);
        rd(2'd3, v2);
        chk(v != v2, "R8 count runs while suppressed", v2, v ^ 1);
        idle(6);
        drained("R8 suppressed");
        wr(2'd2, 32'd0);

        // R9 non-fixed delivery kind
        wr(2'd0, 32'h0000_0433);
        wr(2'd2, 32'd2);
        idle(10);
        rd(2'd3, v); chk(v == 0, "R9 count finished", v, 0);
        drained("R9 non-fixed suppressed");

        // R7 zero load in repeat mode
        wr(2'd0, 32'h0002_0066);
        wr(2'd2, 32'd0);
        idle(12);
        rd(2'd3, v); chk(v == 0, "R7 repeat zero", v, 0);
        drained("R7 no expiry");

        // R10 entry rewrite mid-count
        wr(2'd0, 32'h0000_0010);
        wr(2'd2, 32'd6);
        k = last_edge;
        idle(1);
        wr(2'd0, 32'h0000_0077);
        rd(2'd3, v); chk(v == 32'(6 - (last_edge - k)), "R10 count undisturbed", v, 6 - (last_edge - k));
        expect_irq(k + 7, 8'h77);
        idle(12);
        drained("R10 new vector used");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule